// File: doc/BRIEF.md
# LED Controller Configuration Register File with Staged Duty Update

This block is the configuration store of a multi-channel LED dimming controller. It sits on a two-wire I2C bus as a target. The system clock samples SCL and SDA, and the block answers on SDA through an open-drain enable. A host writes a register pointer followed by any number of data bytes. The pointer steps forward after every data byte. To read, the host writes the pointer, issues a repeated START and then clocks bytes out. The store holds a control byte, a 16-bit duty value and an 8-bit current scale per channel, and a global current byte. It presents the active copy of each of these on parallel outputs for the dimming datapath.

Duty values are double-buffered. Bus writes land in shadow storage, and the outputs change only when the host writes 00h to the commit address while both the hardware enable pin and the software enable bit are high. Scale and global-current writes reach the outputs at once. Writing 00h to the clear address returns the whole map to zero. Neither shutdown condition erases any register.

Top module: `ledreg_top`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 0b01101 followed by `addr_sel_i[1:0]` (bit 0 is R/W, 1 = read). On a mismatch SDA is left released, and the block ignores the bus until the next START.
- R2: In a write transfer the first byte after the address sets the register pointer. Each later data byte is stored at the pointer, and the pointer then increments by one, so a burst fills consecutive addresses.
- R3: A pointer write, then a repeated START with R/W = 1, returns the byte at the pointer MSB first. Each byte the host acknowledges advances the pointer, and the next byte comes from the following address.
- R4: Addresses 01h–48h hold duty shadows, two per channel. For channel k (0-based), the low byte is at 2k+1 and the high byte at 2k+2. Writing them changes `duty_o` in no way, and reads return the shadow value.
- R5: Writing 00h to 49h copies every duty shadow into `duty_o[16k+:16]` = {high, low}. This happens only if `hw_en_i` is 1 and the software enable (control bit 0) is 1. Any other data value, or either enable low, leaves `duty_o` unchanged.
- R6: Scale bytes at 4Ah–6Dh (channel k at 4Ah+k, on `scale_o[8k+:8]`) and the global current at 6Eh appear on their outputs right after the write, with no commit.
- R7: Writing 00h to 7Fh clears every register, shadows and active duty included, to 00h. Nonzero data there has no effect.
- R8: The control byte at 00h stores bit 0 as the software enable, bits 2:1 as the resolution select and bits 6:4 as the oscillator select. Bits 3 and 7 are not stored and read as 0.
- R9: Reads of 49h, 7Fh and unmapped addresses (6Fh–7Eh, 80h–FFh) return 00h. Writes to unmapped addresses are acknowledged and change nothing.
- R10: After reset every output is 0 and SDA is released.
- R11: Registers stay readable and writable while `hw_en_i` is 0 or the software enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 2 | Strap code forming address bits 1:0 |
| hw_en_i | input | 1 | Hardware enable pin, high = running |
| sw_en_o | output | 1 | Software enable bit |
| res_sel_o | output | 2 | Resolution select field |
| osc_sel_o | output | 3 | Oscillator select field |
| gcc_o | output | 8 | Global current byte |
| duty_o | output | 16*NUM_CH | Active duty values, channel k at [16k+:16] |
| scale_o | output | 8*NUM_CH | Scale bytes, channel k at [8k+:8] |

## Verification
The assertions assume a bus host that changes SDA only while SCL is low, except for START and STOP. They also assume each SCL level lasts several system clocks longer than the synchroniser delay, and that reset is held from time zero before release. The bench master holds every SCL phase for six clocks and moves SDA only in the low phase. It releases SDA whenever the target may drive, so the open-drain wire is never fought over. The checks follow the write pulses and the commit gating, observing them through the outputs and through bus read-back.

// File: rtl/ledreg_pkg.sv
package ledreg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_PTR,
    ST_WR,
    ST_RD
  } tgt_state_e;

  localparam logic [4:0] DEV_ID_HI = 5'b01101;
  localparam logic [7:0] A_CTRL    = 8'h00;
  localparam logic [7:0] A_CLEAR   = 8'h7F;
endpackage

// File: rtl/ledreg_bus_sync.sv
module ledreg_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_s
);
  logic [STAGES:0] scl_p, sda_p;
  logic scl_now, scl_old, sda_old;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_i};
      sda_p <= {sda_p[STAGES-1:0], sda_i};
    end
  end

  assign scl_now   = scl_p[STAGES-1];
  assign scl_old   = scl_p[STAGES];
  assign sda_s     = sda_p[STAGES-1];
  assign sda_old   = sda_p[STAGES];
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_s;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/ledreg_i2c_tgt.sv
module ledreg_i2c_tgt
  import ledreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       sda_s,
  input  logic [1:0] addr_sel_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_oe_o,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic [7:0] ptr_o
);
  tgt_state_e state_q;
  logic [3:0] cnt_q;
  logic       in_ack_q, rw_q, mack_q;
  logic [7:0] shreg_q, tx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      in_ack_q  <= 1'b0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      shreg_q   <= '0;
      tx_q      <= '0;
      sda_oe_o  <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      ptr_o     <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_det) begin
        state_q  <= ST_DEV;
        cnt_q    <= '0;
        in_ack_q <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (stop_det) begin
        state_q  <= ST_IDLE;
        in_ack_q <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (state_q != ST_IDLE) begin
        if (scl_rise) begin
          if (in_ack_q) begin
            mack_q <= ~sda_s;
          end else begin
            cnt_q <= cnt_q + 4'd1;
            if (state_q != ST_RD) shreg_q <= {shreg_q[6:0], sda_s};
          end
        end else if (scl_fall) begin
          if (!in_ack_q && cnt_q == 4'd8) begin
            in_ack_q <= 1'b1;
            case (state_q)
              ST_DEV: begin
                if (shreg_q[7:1] == {DEV_ID_HI, addr_sel_i}) begin
                  sda_oe_o <= 1'b1;
                  rw_q     <= shreg_q[0];
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              ST_PTR: begin
                sda_oe_o <= 1'b1;
                ptr_o    <= shreg_q;
              end
              ST_WR: begin
                sda_oe_o  <= 1'b1;
                wr_en_o   <= 1'b1;
                wr_addr_o <= ptr_o;
                wr_data_o <= shreg_q;
                ptr_o     <= ptr_o + 8'd1;
              end
              default: begin
                sda_oe_o <= 1'b0;
                ptr_o    <= ptr_o + 8'd1;
              end
            endcase
          end else if (in_ack_q) begin
            in_ack_q <= 1'b0;
            cnt_q    <= '0;
            case (state_q)
              ST_DEV: begin
                if (rw_q) begin
                  state_q  <= ST_RD;
                  tx_q     <= rd_data_i;
                  sda_oe_o <= ~rd_data_i[7];
                end else begin
                  state_q  <= ST_PTR;
                  sda_oe_o <= 1'b0;
                end
              end
              ST_PTR: begin
                state_q  <= ST_WR;
                sda_oe_o <= 1'b0;
              end
              ST_WR: sda_oe_o <= 1'b0;
              default: begin
                if (mack_q) begin
                  tx_q     <= rd_data_i;
                  sda_oe_o <= ~rd_data_i[7];
                end else begin
                  state_q  <= ST_IDLE;
                  sda_oe_o <= 1'b0;
                end
              end
            endcase
          end else if (state_q == ST_RD && cnt_q != 4'd0) begin
            tx_q     <= {tx_q[6:0], 1'b0};
            sda_oe_o <= ~tx_q[6];
          end
        end
      end
    end
  end
endmodule

// File: rtl/ledreg_regs.sv
module ledreg_regs
  import ledreg_pkg::*;
#(
  parameter int NUM_CH = 36
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hw_en_i,
  input  logic                 wr_en_i,
  input  logic [7:0]           wr_addr_i,
  input  logic [7:0]           wr_data_i,
  input  logic [7:0]           rd_addr_i,
  output logic [7:0]           rd_data_o,
  output logic                 sw_en_o,
  output logic [1:0]           res_sel_o,
  output logic [2:0]           osc_sel_o,
  output logic [7:0]           gcc_o,
  output logic [NUM_CH*16-1:0] duty_o,
  output logic [NUM_CH*8-1:0]  scale_o
);
  localparam int DUTY_BYTES = 2 * NUM_CH;
  localparam int DW = $clog2(DUTY_BYTES);
  localparam int SW = $clog2(NUM_CH);
  localparam logic [7:0] A_DUTY_LO  = 8'd1;
  localparam logic [7:0] A_DUTY_HI  = 8'(DUTY_BYTES);
  localparam logic [7:0] A_COMMIT   = 8'(DUTY_BYTES + 1);
  localparam logic [7:0] A_SCALE_LO = 8'(DUTY_BYTES + 2);
  localparam logic [7:0] A_SCALE_HI = 8'(DUTY_BYTES + 1 + NUM_CH);
  localparam logic [7:0] A_GCC      = 8'(DUTY_BYTES + 2 + NUM_CH);

  logic [7:0] shadow [DUTY_BYTES];
  logic [7:0] active [DUTY_BYTES];
  logic [7:0] scale  [NUM_CH];
  logic       sw_en_q;
  logic [1:0] res_q;
  logic [2:0] osc_q;
  logic [7:0] gcc_q;

  logic map_clr, commit, wr_duty, wr_scale, rd_duty, rd_scale;
  logic [DW-1:0] wd_idx, rd_didx;
  logic [SW-1:0] ws_idx, rd_sidx;

  assign map_clr  = wr_en_i && wr_addr_i == A_CLEAR && wr_data_i == 8'h00;
  assign commit   = wr_en_i && wr_addr_i == A_COMMIT && wr_data_i == 8'h00 && hw_en_i && sw_en_q;
  assign wr_duty  = wr_en_i && wr_addr_i >= A_DUTY_LO && wr_addr_i <= A_DUTY_HI;
  assign wr_scale = wr_en_i && wr_addr_i >= A_SCALE_LO && wr_addr_i <= A_SCALE_HI;
  assign wd_idx   = DW'(wr_addr_i - A_DUTY_LO);
  assign ws_idx   = SW'(wr_addr_i - A_SCALE_LO);
  assign rd_duty  = rd_addr_i >= A_DUTY_LO && rd_addr_i <= A_DUTY_HI;
  assign rd_scale = rd_addr_i >= A_SCALE_LO && rd_addr_i <= A_SCALE_HI;
  assign rd_didx  = DW'(rd_addr_i - A_DUTY_LO);
  assign rd_sidx  = SW'(rd_addr_i - A_SCALE_LO);

  always_ff @(posedge clk) begin
    if (rst || map_clr) begin
      for (int i = 0; i < DUTY_BYTES; i++) begin
        shadow[i] <= '0;
        active[i] <= '0;
      end
      for (int i = 0; i < NUM_CH; i++) scale[i] <= '0;
      sw_en_q <= 1'b0;
      res_q   <= '0;
      osc_q   <= '0;
      gcc_q   <= '0;
    end else begin
      if (wr_en_i && wr_addr_i == A_CTRL) begin
        sw_en_q <= wr_data_i[0];
        res_q   <= wr_data_i[2:1];
        osc_q   <= wr_data_i[6:4];
      end
      if (wr_duty) shadow[wd_idx] <= wr_data_i;
      if (wr_scale) scale[ws_idx] <= wr_data_i;
      if (wr_en_i && wr_addr_i == A_GCC) gcc_q <= wr_data_i;
      if (commit) begin
        for (int i = 0; i < DUTY_BYTES; i++) active[i] <= shadow[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else if (rd_addr_i == A_CTRL) rd_data_o <= {1'b0, osc_q, 1'b0, res_q, sw_en_q};
    else if (rd_duty) rd_data_o <= shadow[rd_didx];
    else if (rd_scale) rd_data_o <= scale[rd_sidx];
    else if (rd_addr_i == A_GCC) rd_data_o <= gcc_q;
    else rd_data_o <= 8'h00;
  end

  assign sw_en_o   = sw_en_q;
  assign res_sel_o = res_q;
  assign osc_sel_o = osc_q;
  assign gcc_o     = gcc_q;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign duty_o[k*16 +: 16] = {active[2*k+1], active[2*k]};
    assign scale_o[k*8 +: 8]  = scale[k];
  end
endmodule

// File: rtl/ledreg_top.sv
module ledreg_top
  import ledreg_pkg::*;
#(
  parameter int NUM_CH      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  input  logic [1:0]           addr_sel_i,
  input  logic                 hw_en_i,
  output logic                 sw_en_o,
  output logic [1:0]           res_sel_o,
  output logic [2:0]           osc_sel_o,
  output logic [7:0]           gcc_o,
  output logic [NUM_CH*16-1:0] duty_o,
  output logic [NUM_CH*8-1:0]  scale_o
);
  logic scl_rise, scl_fall, start_det, stop_det, sda_s;
  logic wr_en;
  logic [7:0] wr_addr, wr_data, ptr, rd_data;

  ledreg_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s)
  );

  ledreg_i2c_tgt u_tgt (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .addr_sel_i(addr_sel_i), .rd_data_i(rd_data), .sda_oe_o(sda_oe_o),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .ptr_o(ptr)
  );

  ledreg_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst(rst), .hw_en_i(hw_en_i), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(ptr),
    .rd_data_o(rd_data), .sw_en_o(sw_en_o), .res_sel_o(res_sel_o),
    .osc_sel_o(osc_sel_o), .gcc_o(gcc_o), .duty_o(duty_o), .scale_o(scale_o)
  );
endmodule

// File: rtl/ledreg_checker.sv
module ledreg_checker #(
  parameter int NUM_CH = 36
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 hw_en_i,
  input logic                 sda_oe_o,
  input logic                 sw_en_o,
  input logic [1:0]           res_sel_o,
  input logic [2:0]           osc_sel_o,
  input logic [7:0]           gcc_o,
  input logic [NUM_CH*16-1:0] duty_o,
  input logic [NUM_CH*8-1:0]  scale_o,
  input logic                 wr_en,
  input logic [7:0]           wr_addr,
  input logic [7:0]           wr_data
);
  localparam logic [7:0] DUTY_HI  = 8'(2 * NUM_CH);
  localparam logic [7:0] SCALE_LO = 8'(2 * NUM_CH + 2);
  localparam logic [7:0] GCC_A    = 8'(3 * NUM_CH + 2);

  // R10
  a_r10_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sda_oe_o && !sw_en_o && gcc_o == 8'h00 && duty_o == '0 && scale_o == '0));

  // R4
  a_r4_shadow_only: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr >= 8'd1 && wr_addr <= DUTY_HI) |=> $stable(duty_o));

  // R5
  a_r5_commit_gated: assert property (@(posedge clk) disable iff (rst)
    !$stable(duty_o) |-> (duty_o == '0 || ($past(hw_en_i) && $past(sw_en_o))));

  // R6
  a_r6_scale_now: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == SCALE_LO) |=> scale_o[7:0] == $past(wr_data));

  // R6
  a_r6_gcc_now: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == GCC_A) |=> gcc_o == $past(wr_data));

  // R7
  a_r7_map_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 8'h7F && wr_data == 8'h00) |=>
      (duty_o == '0 && scale_o == '0 && gcc_o == 8'h00 && !sw_en_o));

  // R8
  a_r8_ctrl_fields: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 8'h00) |=>
      ({osc_sel_o, res_sel_o, sw_en_o} == {$past(wr_data[6:4]), $past(wr_data[2:1]), $past(wr_data[0])}));

  // R9
  a_r9_unmapped_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr > GCC_A && wr_addr < 8'h7F) |=>
      ($stable(duty_o) && $stable(scale_o) && $stable(gcc_o) && $stable(sw_en_o)));
endmodule

bind ledreg_top ledreg_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .hw_en_i(hw_en_i), .sda_oe_o(sda_oe_o),
  .sw_en_o(sw_en_o), .res_sel_o(res_sel_o), .osc_sel_o(osc_sel_o),
  .gcc_o(gcc_o), .duty_o(duty_o), .scale_o(scale_o),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/ledreg_top_tb_top.sv
module ledreg_top_tb_top;
  localparam int NUM_CH = 36;
  localparam int Q = 6;
  // {address, data written, expected read-back}
  localparam logic [23:0] VEC [9] = '{
    24'h00FF77, 24'h013434, 24'h48ABAB, 24'h4A8080, 24'h6DFFFF,
    24'h6E5A5A, 24'h701200, 24'h490700, 24'h7F0100
  };

  logic clk = 1'b0, rst = 1'b1, m_scl = 1'b1, m_sda = 1'b1, hw_en = 1'b1;
  logic [1:0] addr_sel = 2'b10;
  logic sda_oe, sw_en, sda_line;
  logic [1:0] res_sel;
  logic [2:0] osc_sel;
  logic [7:0] gcc;
  logic [NUM_CH*16-1:0] duty;
  logic [NUM_CH*8-1:0] scale;

  assign sda_line = m_sda & ~sda_oe;
  always #10 clk = ~clk;

  ledreg_top #(.NUM_CH(NUM_CH)) dut_i (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .hw_en_i(hw_en), .sw_en_o(sw_en), .res_sel_o(res_sel),
    .osc_sel_o(osc_sel), .gcc_o(gcc), .duty_o(duty), .scale_o(scale)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  logic all_ack;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic send_start();
    m_sda = 1'b1; hq(); m_scl = 1'b1; hq(); m_sda = 1'b0; hq(); m_scl = 1'b0; hq();
  endtask

  task automatic send_stop();
    m_sda = 1'b0; hq(); m_scl = 1'b1; hq(); m_sda = 1'b1; hq();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_sda = b; hq(); m_scl = 1'b1; hq(); s = sda_line; hq(); m_scl = 1'b0; hq();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      d = {d[6:0], s};
    end
    clk_bit(~mack, s);
  endtask

  task automatic i2c_write(input logic [7:0] ptr, input int n);
    logic a;
    send_start();
    send_byte({5'b01101, addr_sel, 1'b0}, a); all_ack = a;
    send_byte(ptr, a); all_ack &= a;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a); all_ack &= a;
    end
    send_stop(); hq();
  endtask

  task automatic i2c_read(input logic [7:0] ptr, input int n);
    logic a;
    logic [7:0] d;
    send_start();
    send_byte({5'b01101, addr_sel, 1'b0}, a); all_ack = a;
    send_byte(ptr, a); all_ack &= a;
    send_start();
    send_byte({5'b01101, addr_sel, 1'b1}, a); all_ack &= a;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      rbuf[i] = d;
    end
    send_stop(); hq();
  endtask

  task automatic probe(input logic [6:0] a7, output logic ack);
    send_start();
    send_byte({a7, 1'b0}, ack);
    send_stop(); hq();
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d);
    wbuf[0] = d;
    i2c_write(a, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    logic ack;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 sda released", sda_oe, 0);
    chk("R10 sw_en", sw_en, 0);
    chk("R10 gcc", gcc, 0);
    chk("R10 duty ch0", duty[15:0], 0);
    chk("R10 scale ch35", scale[35*8 +: 8], 0);

    // table walk: single write then read-back (R4 R6 R8 R9)
    for (int i = 0; i < 9; i++) begin
      wr1(VEC[i][23:16], VEC[i][15:8]);
      chk("R2 single write ack", all_ack, 1);
      i2c_read(VEC[i][23:16], 1);
      chk("R3 read ack", all_ack, 1);
      chk($sformatf("R4/R6/R8/R9 table readback %0d", i), rbuf[0], VEC[i][7:0]);
    end
    // R8 fields of 0xFF write
    chk("R8 sw_en", sw_en, 1);
    chk("R8 res_sel", res_sel, 3);
    chk("R8 osc_sel", osc_sel, 7);
    // R4 shadow only; R6 immediate
    chk("R4 duty ch0 untouched", duty[15:0], 0);
    chk("R4 duty ch35 untouched", duty[35*16 +: 16], 0);
    chk("R6 scale ch0", scale[7:0], 8'h80);
    chk("R6 scale ch35", scale[35*8 +: 8], 8'hFF);
    chk("R6 gcc", gcc, 8'h5A);

    // R1 address match
    probe(7'b0110111, ack); chk("R1 strap mismatch nack", ack, 0);
    probe(7'b1110110, ack); chk("R1 upper mismatch nack", ack, 0);
    probe(7'b0110110, ack); chk("R1 match ack", ack, 1);
    addr_sel = 2'b01;
    probe(7'b0110101, ack); chk("R1 other strap ack", ack, 1);
    probe(7'b0110110, ack); chk("R1 old strap nack", ack, 0);
    addr_sel = 2'b10;

    // R2 burst write, R3 burst read
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    i2c_write(8'h03, 4);
    chk("R2 burst ack", all_ack, 1);
    i2c_read(8'h03, 4);
    chk("R3 burst byte0", rbuf[0], 8'h11);
    chk("R3 burst byte1", rbuf[1], 8'h22);
    chk("R3 burst byte2", rbuf[2], 8'h33);
    chk("R3 burst byte3", rbuf[3], 8'h44);
    i2c_read(8'h47, 2);
    chk("R3 read 47h", rbuf[0], 8'h00);
    chk("R3 read 48h", rbuf[1], 8'hAB);
    chk("R4 duty ch1 before commit", duty[31:16], 0);

    // R5 commit gating, R11 retention in shutdown
    wr1(8'h00, 8'h00);
    wr1(8'h49, 8'h00);
    chk("R5 no commit with sw off", duty[31:16], 0);
    i2c_read(8'h03, 1);
    chk("R11 read in sw shutdown", rbuf[0], 8'h11);
    wr1(8'h00, 8'h01);
    hw_en = 1'b0;
    wr1(8'h49, 8'h00);
    chk("R5 no commit with pin low", duty[31:16], 0);
    wr1(8'h4B, 8'h55);
    chk("R11 scale write in pin shutdown", scale[15:8], 8'h55);
    i2c_read(8'h4B, 1);
    chk("R11 read in pin shutdown", rbuf[0], 8'h55);
    hw_en = 1'b1;
    wr1(8'h49, 8'h01);
    chk("R5 nonzero commit ignored", duty[31:16], 0);
    wr1(8'h49, 8'h00);
    chk("R5 commit ch0", duty[15:0], 16'h0034);
    chk("R5 commit ch1", duty[31:16], 16'h2211);
    chk("R5 commit ch2", duty[47:32], 16'h4433);
    chk("R5 commit ch35", duty[35*16 +: 16], 16'hAB00);

    // R7 clear
    wr1(8'h7F, 8'h00);
    chk("R7 duty cleared", duty[31:16], 0);
    chk("R7 scale cleared", scale[7:0], 0);
    chk("R7 gcc cleared", gcc, 0);
    chk("R7 sw_en cleared", sw_en, 0);
    i2c_read(8'h01, 1);
    chk("R7 shadow cleared", rbuf[0], 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule